// File: doc/BRIEF.md
# Oversampling DPLL Bit-Clock Recovery

This block recovers a bit clock from NRZ serial receive data. It runs on a reference clock at sixteen ticks per nominal bit. A 4-bit phase count marks the position inside the current bit. One wrap of the count makes one recovered clock pulse. The data line is sampled in the middle of each bit to give the received bit.

Each data transition is measured against the expected bit boundary, which is phase 0. An isolated transition a few ticks late stretches the current bit by one tick. One a few ticks early shrinks it by one tick. Transitions near the boundary or far from it leave the phase alone. A transition that comes fewer than sixteen ticks after the previous one is treated as interference and is never used for correction.

The same recovered pulse can also drive a transmitter. Bus stations without a central clock then keep their transmit timing aligned with the line.

Top module: `dpll_clkrec`

## Requirements
- R1: While `rst_n` is low, `rclk_pulse`, `rbit` and `tclk_pulse` are 0 and the phase count is 0. After reset is released with `en` high and no data transitions, the first `rclk_pulse` comes on the 16th enabled clock.
- R2: Without corrections, `rclk_pulse` is high for exactly one cycle every 16 enabled cycles. It is never high on two consecutive cycles.
- R3: `rxd` passes through two synchronizing flops. `rbit` takes the synchronized value in the enabled cycle whose phase count is 8 and holds it otherwise. A transition on `rxd` is classified three clock edges after it changes, against the phase count held at that edge.
- R4: An isolated transition classified at phase count 1, 2, 3 or 4 (late) holds the count for one tick. The current bit then lasts 17 ticks.
- R5: An isolated transition classified at phase count 12, 13, 14 or 15 (early) advances the count by two. The current bit then lasts 15 ticks.
- R6: A transition classified at phase count 0 or at 5 to 11 makes no correction, and the bit lasts 16 ticks.
- R7: A transition counts as isolated only if at least 16 enabled cycles have passed since the previous transition, or none has occurred since reset. A closer transition is interference: it makes no correction and restarts the spacing count.
- R8: At most one correction is applied inside one recovered bit period.
- R9: While `en` is low, `rclk_pulse` stays 0 and the phase count, spacing count and `rbit` hold their values.
- R10: With `TX_FROM_RX` = 1 (the default), `tclk_pulse` equals `rclk_pulse` in every cycle. With `TX_FROM_RX` = 0 it stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, 16 ticks per nominal bit |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Tick enable; low freezes recovery |
| rxd | input | 1 | Asynchronous NRZ serial data |
| rclk_pulse | output | 1 | One-cycle recovered receive clock pulse per bit |
| rbit | output | 1 | Data bit sampled at mid-bit |
| tclk_pulse | output | 1 | Recovered transmit clock pulse |

## Verification
A wrong phase count or correction decision shows up as a recovered pulse 15, 16 or 17 cycles away from where it belongs. This is visible at the next wrap, at most 17 cycles after the transition that caused it. A wrong spacing count shows up as a correction made or missed on the following transition. A wrong sample point shows as a wrong `rbit` within one bit period. The bench places single transitions at chosen phases and pairs of transitions at spacings of 15 and 16 ticks, then measures pulse spacing. It then replays jittered and glitchy random data with enable gaps against a tick-by-tick reference model.

// File: rtl/dpll_clkrec.sv
module dpll_clkrec #(
  parameter int PH_BITS    = 4,
  parameter int ADJ_SPAN   = 4,
  parameter bit TX_FROM_RX = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rxd,
  output logic rclk_pulse,
  output logic rbit,
  output logic tclk_pulse
);
  localparam int TICKS = 1 << PH_BITS;
  localparam int MID   = TICKS / 2;
  localparam int GW    = PH_BITS + 1;

  logic s1, s2, s3;
  logic [PH_BITS-1:0] ph;
  logic [GW-1:0] gap;
  logic corr_seen;

  wire edg   = en && (s2 != s3);
  wire iso   = (gap == GW'(TICKS));
  wire late  = edg && iso && (ph != '0) && (ph <= PH_BITS'(ADJ_SPAN));
  wire early = edg && iso && (ph >= PH_BITS'(TICKS - ADJ_SPAN));
  wire [1:0] step = late ? 2'd0 : (early ? 2'd2 : 2'd1);
  wire [PH_BITS:0] nxt = {1'b0, ph} + {{(PH_BITS-1){1'b0}}, step};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
      ph <= '0;
      gap <= GW'(TICKS);
      rclk_pulse <= 1'b0;
      rbit <= 1'b0;
      corr_seen <= 1'b0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      s3 <= s2;
      if (en) begin
        ph <= nxt[PH_BITS-1:0];
        rclk_pulse <= nxt[PH_BITS];
        if (ph == PH_BITS'(MID)) rbit <= s2;
        gap <= edg ? GW'(1) : (iso ? gap : gap + GW'(1));
        corr_seen <= nxt[PH_BITS] ? 1'b0 : (corr_seen | late | early);
      end else begin
        rclk_pulse <= 1'b0;
      end
    end
  end

  generate
    if (TX_FROM_RX) begin : g_tx_shared
      assign tclk_pulse = rclk_pulse;
    end else begin : g_tx_off
      assign tclk_pulse = 1'b0;
    end
  endgenerate

  assert_pulse_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rclk_pulse |=> !rclk_pulse);
  assert_sample_point_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && ph == PH_BITS'(MID)) |=> $stable(rbit));
  assert_late_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    late |=> (ph == $past(ph)));
  assert_quiet_zone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (edg && (ph == '0 || (ph > PH_BITS'(ADJ_SPAN) && ph < PH_BITS'(TICKS - ADJ_SPAN))))
    |=> (ph == PH_BITS'($past(ph) + 1'b1)));
  assert_interference_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (edg && !iso) |=> (ph == PH_BITS'($past(ph) + 1'b1)));
  assert_one_corr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (late || early) |-> !corr_seen);
  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!rclk_pulse && $stable(ph) && $stable(rbit) && $stable(gap)));
endmodule

// File: tb/dpll_clkrec_tb.sv
module dpll_clkrec_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic rxd = 1'b0;
  logic rclk_pulse, rbit, tclk_pulse;
  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dpll_clkrec u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .rxd(rxd),
    .rclk_pulse(rclk_pulse), .rbit(rbit), .tclk_pulse(tclk_pulse)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference model of the requirements, advanced once per clock edge.
  bit m_s1, m_s2, m_s3, m_pulse, m_bit;
  int m_ph, m_gap;

  function automatic int model_next(int ph, bit e, bit iso);
    if (e && iso && ph >= 1 && ph <= 4) return ph;       // R4
    if (e && iso && ph >= 12) return ph + 2;             // R5
    return ph + 1;                                       // R6, R7
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_s3 <= 0; m_pulse <= 0; m_bit <= 0;
      m_ph <= 0; m_gap <= 16;
    end else begin
      m_s1 <= rxd; m_s2 <= m_s1; m_s3 <= m_s2;
      if (en) begin
        int nx;
        nx = model_next(m_ph, m_s2 != m_s3, m_gap >= 16);
        m_pulse <= (nx >= 16);
        m_ph <= nx % 16;
        if (m_ph == 8) m_bit <= m_s2;
        m_gap <= (m_s2 != m_s3) ? 1 : ((m_gap < 16) ? m_gap + 1 : m_gap);
      end else begin
        m_pulse <= 0;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check(rclk_pulse == m_pulse, "R2/R4/R5 model pulse", rclk_pulse, m_pulse);
      check(rbit == m_bit, "R3 model rbit", rbit, m_bit);
      check(tclk_pulse == rclk_pulse, "R10 tx pulse", tclk_pulse, rclk_pulse);
    end
  end

  task automatic wait_pulse();
    do @(negedge clk); while (!rclk_pulse);
  endtask

  // Toggles rxd at offsets k1/k2 after a pulse; returns offset of the second pulse.
  task automatic run_toggles(int k1, int k2, output int p2);
    int cnt = 0;
    p2 = -1;
    wait_pulse();
    for (int i = 0; i < 60; i++) begin
      if (i == k1 || i == k2) rxd = ~rxd;
      @(negedge clk);
      if (rclk_pulse) begin
        cnt++;
        if (cnt == 2) begin
          p2 = i + 1;
          break;
        end
      end
    end
    repeat (2) wait_pulse();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
    end
  end

  initial begin
    int p, cnt;
    bit held;
    void'($urandom(32'd20240611));
    repeat (4) begin
      @(negedge clk);
      check(rclk_pulse == 0, "R1 reset pulse", rclk_pulse, 0);
      check(rbit == 0, "R1 reset rbit", rbit, 0);
      check(tclk_pulse == 0, "R1 reset tx", tclk_pulse, 0);
    end
    rst_n = 1'b1;
    en = 1'b1;
    cmp_on = 1'b1;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!rclk_pulse && cnt < 40);
    check(cnt == 16, "R1 first pulse", cnt, 16);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!rclk_pulse && cnt < 40);
    check(cnt == 16, "R2 period", cnt, 16);

    run_toggles(0, -1, p);  check(p == 33, "R4 late phase 2", p, 33);
    run_toggles(2, -1, p);  check(p == 33, "R4 late phase 4", p, 33);
    run_toggles(3, -1, p);  check(p == 32, "R6 phase 5", p, 32);
    run_toggles(8, -1, p);  check(p == 32, "R6 phase 10", p, 32);
    run_toggles(14, -1, p); check(p == 32, "R6 phase 0", p, 32);
    run_toggles(10, -1, p); check(p == 31, "R5 early phase 12", p, 31);
    run_toggles(13, -1, p); check(p == 31, "R5 early phase 15", p, 31);
    run_toggles(8, 16, p);  check(p == 32, "R7 interference late", p, 32);
    run_toggles(10, 25, p); check(p == 31, "R7 gap 15 rejected", p, 31);
    run_toggles(10, 26, p); check(p == 30, "R7 R8 gap 16 accepted", p, 30);
    run_toggles(0, 16, p);  check(p == 34, "R8 one per period", p, 34);

    rxd = 1'b1;
    repeat (3) wait_pulse();
    check(rbit == 1, "R3 mid-bit sample", rbit, 1);

    held = rbit;
    en = 1'b0;
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      if (i == 5) rxd = 1'b0;
      @(negedge clk);
      if (rclk_pulse) cnt++;
      if (rbit != held) cnt++;
    end
    check(cnt == 0, "R9 frozen while disabled", cnt, 0);
    en = 1'b1;

    for (int b = 0; b < 250; b++) begin
      int len;
      len = 14 + int'($urandom_range(4));
      rxd = 1'($urandom_range(1));
      for (int t = 0; t < len; t++) begin
        if ($urandom_range(39) == 0) en = 1'b0;
        else en = 1'b1;
        if (t == 6 && $urandom_range(7) == 0) rxd = ~rxd;
        if (t == 8 && $urandom_range(7) == 0) rxd = ~rxd;
        @(negedge clk);
      end
    end
    en = 1'b1;
    repeat (20) @(negedge clk);
    done = 1'b1;
    summary();
  end
endmodule